// File: doc/BRIEF.md
# Descriptor-Chained Lookup Table Refill Engine

This block fills rectangular windows of a page-address lookup table. Software builds a linked chain of descriptors in memory. Each descriptor names a rectangle, a target table and a pointer to the 32-bit entries for that rectangle. Software then writes the chain's head address into one engine's descriptor register. The block fetches each descriptor over a single-word memory read port and streams the rectangle's entries, row by row, into a table write port. It follows the next pointers until one is zero, then flags the engine ready and raises a completion bit in that engine's interrupt lane.

Several engines share one walker. Pending engines are taken in round-robin order, and each one is served for its whole chain. Writing zero to an engine's descriptor register cancels that engine's work. Read-only registers report the engine count, the table count and the table geometry, so software can size its buffers.

Top module: `chainRefill`

## Requirements
- R1: After reset, every engine's status reads READY=1 and ERR=0, the interrupt status reads 0, `irq` is low, and `memReq` and `lutWe` are low.
- R2: Register 0x00 returns the engine count in bits [28:24] and the table count in bits [20:16]. Register 0x04 returns table width/32 in bits [19:16] and table height/32 in bits [27:24].
- R3: The entry at table `t`, column `x`, row `y` is written to `lutIdx = t*W*H + y*W + x`. A rectangle's entries are read as consecutive words from its data pointer in row-major order, and exactly (x1-x0+1)*(y1-y0+1) table writes occur for it.
- R4: Writing 0 to an engine's descriptor register cancels its pending or running walk. On the next cycle its status reads READY=1 and ERR=0, and no further table writes occur for that walk.
- R5: Engine n has its descriptor register at 0x10+4n and its status at 0x20+4n (bit 0 READY, bit 1 ERR). A nonzero write clears READY and starts the walk. READY returns to 1 only after the descriptor whose next pointer is 0 has finished.
- R6: A descriptor is five words at its address: +0 {y0[31:16], x0[15:0]}, +4 {y1, x1}, +8 control (bit 0 start, bits [12:8] table id), +12 data pointer, +16 next pointer. A nonzero next pointer continues the walk at that address.
- R7: A descriptor address (head or next) or data pointer whose low four bits are not zero sets ERR and READY. It also sets error bit 2 of the engine's interrupt lane and ends the walk, with no table writes for that descriptor.
- R8: A descriptor with x1<x0, y1<y0, x1>=W, y1>=H, table id >= table count, or start bit 0 produces the same error result as R7, with no table writes.
- R9: Interrupt status at 0x08 gives engine n bits [8n+7:8n], with bit 1 for chain done and bit 2 for error. Writing ones clears those bits. `irq` is the OR of the status under the per-lane mask 0x7E.
- R10: Engines that are pending when the walker is busy wait. Each is then served in turn, starting with the engine after the one last served.
- R11: `memReq` stays high with a stable `memAddr` until `memAck`, and each acknowledge delivers one word. A walk costs 5 reads per descriptor plus one per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read byte address |
| memAck | input | 1 | Read acknowledge, one word |
| memData | input | 32 | Read data, valid with memAck |
| lutWe | output | 1 | Table write enable |
| lutIdx | output | IDX_W (11) | Flat table index |
| lutData | output | 32 | Table write data |
| irq | output | 1 | Interrupt line |

## Verification
The bench sweeps many rectangles across both tables, including single entries, full rows, full columns and the far corners. Any error in the row stride or the table-offset arithmetic would land entries on neighbours or miss the last column. Chains of three descriptors check that a walker which stopped after the first area, or re-read the head, leaves later areas blank and miscounts memory reads. Every alignment and bounds failure is run on its own: a design that skipped one of these checks would write entries, or report READY without ERR. A mid-walk cancel must stop the write stream at once, and a design that finished the area would show a growing write count.

// File: rtl/chainRefillPkg.sv
`timescale 1ns/1ps
package chainRefillPkg;
  // strobes from the walker control to the address/geometry datapath
  typedef struct packed {
    logic       loadHead;   // rdAddr <= chain head
    logic       loadWord;   // capture a descriptor word, advance rdAddr
    logic [2:0] wordSel;    // which descriptor word is on memData
    logic       startArea;  // rdAddr <= data pointer, cursor <= (x0,y0)
    logic       stepEntry;  // one entry written, advance cursor and rdAddr
    logic       loadNext;   // rdAddr <= next pointer
  } refillStrb_t;
endpackage

// File: rtl/refillDatapath.sv
`timescale 1ns/1ps
module refillDatapath
  import chainRefillPkg::*;
#(
  parameter int NUM_LUT = 2,
  parameter int LUT_W   = 32,
  parameter int LUT_H   = 32,
  parameter int IDX_W   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  refillStrb_t       strb,
  input  logic [31:0]       headPtr,
  input  logic [31:0]       memData,
  output logic [31:0]       rdAddr,
  output logic [IDX_W-1:0]  lutIdx,
  output logic              areaBad,
  output logic              lastEntry,
  output logic              nextZero,
  output logic              addrMisaligned
);
  localparam int LUT_SZ = LUT_W * LUT_H;

  logic [15:0] x0, y0, x1, y1, curX, curY;
  logic        startBit;
  logic [4:0]  lutId;
  logic [31:0] dataPtr, nextPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr <= '0; x0 <= '0; y0 <= '0; x1 <= '0; y1 <= '0;
      curX <= '0; curY <= '0; startBit <= 1'b0; lutId <= '0;
      dataPtr <= '0; nextPtr <= '0;
    end else begin
      if (strb.loadHead)       rdAddr <= headPtr;
      else if (strb.loadWord)  rdAddr <= rdAddr + 32'd4;
      else if (strb.startArea) rdAddr <= dataPtr;
      else if (strb.stepEntry) rdAddr <= rdAddr + 32'd4;
      else if (strb.loadNext)  rdAddr <= nextPtr;

      if (strb.loadWord) begin
        case (strb.wordSel)
          3'd0: {y0, x0} <= memData;
          3'd1: {y1, x1} <= memData;
          3'd2: begin startBit <= memData[0]; lutId <= memData[12:8]; end
          3'd3: dataPtr <= memData;
          default: nextPtr <= memData;
        endcase
      end

      if (strb.startArea) begin
        curX <= x0;
        curY <= y0;
      end else if (strb.stepEntry) begin
        if (curX == x1) begin
          curX <= x0;
          curY <= curY + 16'd1;
        end else begin
          curX <= curX + 16'd1;
        end
      end
    end
  end

  assign areaBad = !startBit || (x1 < x0) || (y1 < y0) ||
                   (x1 >= 16'(LUT_W)) || (y1 >= 16'(LUT_H)) ||
                   (lutId >= 5'(NUM_LUT)) || (dataPtr[3:0] != 4'd0);
  assign lastEntry      = (curX == x1) && (curY == y1);
  assign nextZero       = (nextPtr == 32'd0);
  assign addrMisaligned = (rdAddr[3:0] != 4'd0);
  assign lutIdx = IDX_W'(lutId) * IDX_W'(LUT_SZ) + IDX_W'(curY) * IDX_W'(LUT_W) + IDX_W'(curX);

  // R8
  in_bounds_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepEntry |-> (curX < 16'(LUT_W) && curY < 16'(LUT_H) && curX >= x0 && curY >= y0));
endmodule

// File: rtl/refillCtrl.sv
`timescale 1ns/1ps
module refillCtrl
  import chainRefillPkg::*;
#(
  parameter int          NUM_ENG  = 2,
  parameter int          NUM_LUT  = 2,
  parameter int          LUT_W    = 32,
  parameter int          LUT_H    = 32,
  parameter logic [31:0] IRQ_MASK = 32'h7E7E7E7E
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memReq,
  input  logic        memAck,
  output logic        lutWe,
  output logic        irq,
  output refillStrb_t strb,
  output logic [31:0] headPtr,
  input  logic        areaBad,
  input  logic        lastEntry,
  input  logic        nextZero,
  input  logic        addrMisaligned
);
  localparam int EW = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;
  localparam logic [7:0] HW_OFF = 8'h00, GEO_OFF = 8'h04, IRQ_OFF = 8'h08;
  localparam logic [7:0] DESC_OFF = 8'h10, STAT_OFF = 8'h20;
  localparam logic [31:0] HW_INFO  = (32'(NUM_ENG) << 24) | (32'(NUM_LUT) << 16);
  localparam logic [31:0] GEO_INFO = (32'(LUT_H / 32) << 24) | (32'(LUT_W / 32) << 16);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_DATA, S_NEXT} walkState_t;
  walkState_t state;

  logic [31:0]        descReg [NUM_ENG];
  logic [NUM_ENG-1:0] engReady, engErr, pending;
  logic [31:0]        irqStat, irqSet, irqClr;
  logic [EW-1:0]      activeEng, rrPtr, pickEng;
  logic               pickValid, failEv, doneEv;
  logic [2:0]         wordCnt;

  // round-robin pick, starting at rrPtr
  always_comb begin
    pickValid = 1'b0;
    pickEng   = '0;
    for (int i = 0; i < NUM_ENG; i++) begin
      int c;
      c = int'(rrPtr) + i;
      if (c >= NUM_ENG) c = c - NUM_ENG;
      if (!pickValid && pending[c]) begin
        pickValid = 1'b1;
        pickEng   = EW'(c);
      end
    end
  end

  assign headPtr = descReg[pickEng];
  assign failEv  = (state == S_FETCH && wordCnt == 3'd0 && addrMisaligned) ||
                   (state == S_CHECK && areaBad);
  assign doneEv  = (state == S_NEXT) && nextZero;
  assign irqClr  = (regWrEn && regAddr == IRQ_OFF) ? regWrData : 32'd0;
  assign irq     = |(irqStat & IRQ_MASK);

  always_comb begin
    irqSet = '0;
    if (failEv) irqSet[int'(activeEng) * 8 + 2] = 1'b1;
    if (doneEv) irqSet[int'(activeEng) * 8 + 1] = 1'b1;
  end

  always_comb begin
    strb   = '0;
    memReq = 1'b0;
    lutWe  = 1'b0;
    case (state)
      S_IDLE:  strb.loadHead = pickValid;
      S_FETCH: if (!(wordCnt == 3'd0 && addrMisaligned)) begin
                 memReq = 1'b1;
                 strb.loadWord = memAck;
                 strb.wordSel  = wordCnt;
               end
      S_CHECK: strb.startArea = !areaBad;
      S_DATA:  begin
                 memReq = 1'b1;
                 lutWe = memAck;
                 strb.stepEntry = memAck;
               end
      default: strb.loadNext = !nextZero;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; activeEng <= '0; rrPtr <= '0; wordCnt <= '0;
      engReady <= '1; engErr <= '0; pending <= '0; irqStat <= '0;
      for (int e = 0; e < NUM_ENG; e++) descReg[e] <= '0;
    end else begin
      case (state)
        S_IDLE: if (pickValid) begin
          activeEng <= pickEng;
          pending[pickEng] <= 1'b0;
          rrPtr <= (pickEng == EW'(NUM_ENG - 1)) ? '0 : pickEng + 1'b1;
          wordCnt <= '0;
          state <= S_FETCH;
        end
        S_FETCH: if (!failEv && memAck) begin
          wordCnt <= wordCnt + 3'd1;
          if (wordCnt == 3'd4) state <= S_CHECK;
        end
        S_CHECK: if (!areaBad) state <= S_DATA;
        S_DATA:  if (memAck && lastEntry) state <= S_NEXT;
        default: if (nextZero) begin
          engReady[activeEng] <= 1'b1;
          state <= S_IDLE;
        end else begin
          wordCnt <= '0;
          state <= S_FETCH;
        end
      endcase
      if (failEv) begin
        engErr[activeEng]   <= 1'b1;
        engReady[activeEng] <= 1'b1;
        state <= S_IDLE;
      end
      irqStat <= (irqStat & ~irqClr) | irqSet;
      // software writes override the walker for the addressed engine
      for (int e = 0; e < NUM_ENG; e++) begin
        if (regWrEn && regAddr == DESC_OFF + 8'(4 * e)) begin
          descReg[e]  <= regWrData;
          pending[e]  <= (regWrData != 32'd0);
          engReady[e] <= (regWrData == 32'd0);
          engErr[e]   <= 1'b0;
          if ((state != S_IDLE && activeEng == EW'(e)) ||
              (state == S_IDLE && pickValid && pickEng == EW'(e)))
            state <= S_IDLE;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      HW_OFF:  regRdData = HW_INFO;
      GEO_OFF: regRdData = GEO_INFO;
      IRQ_OFF: regRdData = irqStat;
      default:
        for (int e = 0; e < NUM_ENG; e++) begin
          if (regAddr == DESC_OFF + 8'(4 * e)) regRdData = descReg[e];
          if (regAddr == STAT_OFF + 8'(4 * e)) regRdData = {30'd0, engErr[e], engReady[e]};
        end
    endcase
  end

  // R5
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !engReady[activeEng]);

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_cancelChk
    // R4
    cancel_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == DESC_OFF + 8'(4 * g) && regWrData == 32'd0)
      |=> (engReady[g] && !pending[g]));
  end
endmodule

// File: rtl/chainRefill.sv
`timescale 1ns/1ps
module chainRefill
  import chainRefillPkg::*;
#(
  parameter int NUM_ENG = 2,
  parameter int NUM_LUT = 2,
  parameter int LUT_W   = 32,
  parameter int LUT_H   = 32,
  parameter int IDX_W   = $clog2(NUM_LUT * LUT_W * LUT_H)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic             memReq,
  output logic [31:0]      memAddr,
  input  logic             memAck,
  input  logic [31:0]      memData,
  output logic             lutWe,
  output logic [IDX_W-1:0] lutIdx,
  output logic [31:0]      lutData,
  output logic             irq
);
  refillStrb_t strb;
  logic [31:0] headPtr;
  logic        areaBad, lastEntry, nextZero, addrMisaligned;

  refillCtrl #(.NUM_ENG(NUM_ENG), .NUM_LUT(NUM_LUT), .LUT_W(LUT_W), .LUT_H(LUT_H),
               .IRQ_MASK(32'h7E7E7E7E)) ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memAck(memAck), .lutWe(lutWe), .irq(irq), .strb(strb), .headPtr(headPtr),
    .areaBad(areaBad), .lastEntry(lastEntry), .nextZero(nextZero),
    .addrMisaligned(addrMisaligned));

  refillDatapath #(.NUM_LUT(NUM_LUT), .LUT_W(LUT_W), .LUT_H(LUT_H), .IDX_W(IDX_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .headPtr(headPtr), .memData(memData),
    .rdAddr(memAddr), .lutIdx(lutIdx), .areaBad(areaBad), .lastEntry(lastEntry),
    .nextZero(nextZero), .addrMisaligned(addrMisaligned));

  assign lutData = memData;

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !regWrEn) |=> (memReq && $stable(memAddr)));
endmodule

// File: tb/chainRefill_test.sv
`timescale 1ns/1ps
module chainRefill_test;
  logic        clk = 1'b0;
  logic        rstN, regWrEn, memAck, memReq, lutWe, irq;
  logic [7:0]  regAddr;
  logic [31:0] regWrData, regRdData, memAddr, memData, lutData;
  logic [10:0] lutIdx;

  logic [31:0] bmem   [1024];
  logic [31:0] lutMem [2048];
  int vecs = 0, fails = 0, wrCount = 0, ackCount = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  chainRefill uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memData(memData), .lutWe(lutWe),
    .lutIdx(lutIdx), .lutData(lutData), .irq(irq));

  // memory model: one word per acknowledge, answered half a cycle after request
  initial memAck = 1'b0;
  always @(negedge clk) begin
    if (memReq && !memAck) begin
      memAck  <= 1'b1;
      memData <= bmem[memAddr[11:2]];
    end else begin
      memAck <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (lutWe) begin
      lutMem[lutIdx] <= lutData;
      wrCount <= wrCount + 1;
    end
    if (memReq && memAck) ackCount <= ackCount + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitReady(input int e);
    logic [31:0] s;
    int n;
    n = 0;
    do begin
      @(negedge clk);
      regRd(8'(8'h20 + 4 * e), s);
      n++;
    end while (!s[0] && n < 4000);
  endtask

  task automatic clearModel();
    for (int i = 0; i < 2048; i++) lutMem[i] = 32'hFFFF_FFFF;
    wrCount = 0;
    ackCount = 0;
  endtask

  function automatic logic [31:0] entryVal(input int tag, input int i);
    return 32'hA000_0000 | (32'(tag) << 12) | 32'(i);
  endfunction

  // descriptor plus its data words
  task automatic putArea(input int dAddr, input int x0, input int y0, input int x1,
                         input int y1, input int ctl, input int dPtr, input int nxt,
                         input int tag);
    int n;
    bmem[dAddr >> 2]       = {16'(y0), 16'(x0)};
    bmem[(dAddr >> 2) + 1] = {16'(y1), 16'(x1)};
    bmem[(dAddr >> 2) + 2] = 32'(ctl);
    bmem[(dAddr >> 2) + 3] = 32'(dPtr);
    bmem[(dAddr >> 2) + 4] = 32'(nxt);
    n = (x1 >= x0 && y1 >= y0) ? (x1 - x0 + 1) * (y1 - y0 + 1) : 0;
    if (n > 256) n = 256;
    for (int i = 0; i < n; i++) bmem[((dPtr & ~15) >> 2) + i] = entryVal(tag, i);
  endtask

  task automatic checkArea(input string tag, input int x0, input int y0, input int x1,
                           input int y1, input int lut, input int dPtr);
    int i;
    i = 0;
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        chk(tag, lutMem[lut * 1024 + y * 32 + x], bmem[(dPtr >> 2) + i]);
        i++;
      end
  endtask

  task automatic clearIrq(input logic [31:0] bits);
    logic [31:0] v;
    regWr(8'h08, bits);
    regRd(8'h08, v);
    chk("R9 status cleared by writing ones", v, 32'd0);
    chk("R9 irq low after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic runOne(input int e, input int x0, input int y0, input int x1,
                        input int y1, input int lut, input int tag);
    logic [31:0] v;
    int n;
    n = (x1 - x0 + 1) * (y1 - y0 + 1);
    putArea(32'h100, x0, y0, x1, y1, 1 | (lut << 8), 32'h400, 0, tag);
    clearModel();
    regWr(8'(8'h10 + 4 * e), 32'h100);
    regRd(8'(8'h20 + 4 * e), v);
    chk("R5 READY clear while walking", v, 32'd0);
    waitReady(e);
    regRd(8'(8'h20 + 4 * e), v);
    chk("R5 READY after last descriptor", v, 32'd1);
    chk("R3 table write count", 32'(wrCount), 32'(n));
    chk("R11 memory reads per walk", 32'(ackCount), 32'(n + 5));
    checkArea("R3 entry placement", x0, y0, x1, y1, lut, 32'h400);
    regRd(8'h08, v);
    chk("R9 done bit in engine lane", v, 32'd1 << (8 * e + 1));
    chk("R9 irq high on done", {31'd0, irq}, 32'd1);
    clearIrq(32'd1 << (8 * e + 1));
  endtask

  task automatic runErr(input string tag, input int e, input int head, input int expWr,
                        input int expAck);
    logic [31:0] v;
    clearModel();
    regWr(8'(8'h10 + 4 * e), 32'(head));
    waitReady(e);
    regRd(8'(8'h20 + 4 * e), v);
    chk({tag, " status ERR|READY"}, v, 32'd3);
    chk({tag, " table writes"}, 32'(wrCount), 32'(expWr));
    chk({tag, " memory reads"}, 32'(ackCount), 32'(expAck));
    regRd(8'h08, v);
    chk({tag, " error bit in lane"}, v, 32'd1 << (8 * e + 2));
    chk({tag, " irq high"}, {31'd0, irq}, 32'd1);
    clearIrq(32'd1 << (8 * e + 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c1;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    for (int i = 0; i < 1024; i++) bmem[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRd(8'h20, v); chk("R1 engine 0 status", v, 32'd1);
    regRd(8'h24, v); chk("R1 engine 1 status", v, 32'd1);
    regRd(8'h08, v); chk("R1 interrupt status", v, 32'd0);
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    chk("R1 no request or write", {30'd0, memReq, lutWe}, 32'd0);

    // R2 identification registers
    regRd(8'h00, v); chk("R2 hardware info", v, 32'h0202_0000);
    regRd(8'h04, v); chk("R2 geometry", v, 32'h0101_0000);

    // R3/R5/R9/R11 sweep of rectangles over both engines and tables
    for (int k = 0; k < 12; k++) begin
      int x0, y0;
      x0 = (k * 5) % 24;
      y0 = (k * 3) % 28;
      runOne(k % 2, x0, y0, x0 + (k % 4) * 2, y0 + (k % 3), k % 2, k);
    end
    runOne(1, 0, 31, 31, 31, 1, 20);   // full bottom row, last table
    runOne(0, 31, 0, 31, 31, 0, 21);   // full right column
    runOne(1, 31, 31, 31, 31, 1, 22);  // single far corner entry

    // R6 three-descriptor chain on engine 1
    putArea(32'h100, 2, 3, 5, 4, 32'h001, 32'h400, 32'h140, 30);
    putArea(32'h140, 10, 20, 10, 25, 32'h101, 32'h500, 32'h180, 31);
    putArea(32'h180, 28, 30, 31, 31, 32'h101, 32'h600, 0, 32);
    clearModel();
    regWr(8'h14, 32'h100);
    waitReady(1);
    regRd(8'h24, v); chk("R6 chain ends READY", v, 32'd1);
    chk("R6 chain write count", 32'(wrCount), 32'd22);
    chk("R11 chain memory reads", 32'(ackCount), 32'd37);
    checkArea("R6 chain area 0", 2, 3, 5, 4, 0, 32'h400);
    checkArea("R6 chain area 1", 10, 20, 10, 25, 1, 32'h500);
    checkArea("R6 chain area 2", 28, 30, 31, 31, 1, 32'h600);
    clearIrq(32'h0000_0200);

    // R7 alignment errors
    runErr("R7 misaligned head", 0, 32'h104, 0, 0);
    putArea(32'h100, 0, 0, 1, 0, 32'h001, 32'h408, 0, 40);
    runErr("R7 misaligned data pointer", 1, 32'h100, 0, 5);
    putArea(32'h100, 4, 4, 5, 4, 32'h001, 32'h400, 32'h148, 41);
    runErr("R7 misaligned next pointer", 0, 32'h100, 2, 7);

    // R8 bad areas
    putArea(32'h100, 5, 0, 4, 0, 32'h001, 32'h400, 0, 42);
    runErr("R8 x1 below x0", 0, 32'h100, 0, 5);
    putArea(32'h100, 0, 30, 0, 32, 32'h001, 32'h400, 0, 43);
    runErr("R8 y1 past height", 1, 32'h100, 0, 5);
    putArea(32'h100, 0, 0, 0, 0, 32'h201, 32'h400, 0, 44);
    runErr("R8 table id out of range", 0, 32'h100, 0, 5);
    putArea(32'h100, 0, 0, 0, 0, 32'h000, 32'h400, 0, 45);
    runErr("R8 start bit clear", 1, 32'h100, 0, 5);
    putArea(32'h100, 0, 5, 0, 4, 32'h001, 32'h400, 0, 46);
    runErr("R8 y1 below y0", 0, 32'h100, 0, 5);
    putArea(32'h100, 0, 0, 32, 0, 32'h001, 32'h400, 0, 47);
    runErr("R8 x1 past width", 1, 32'h100, 0, 5);

    // R4 cancel in the middle of a long area
    putArea(32'h100, 0, 0, 31, 7, 32'h001, 32'h400, 0, 50);
    clearModel();
    regWr(8'h10, 32'h100);
    repeat (40) @(negedge clk);
    regWr(8'h10, 32'h0);
    regRd(8'h20, v); chk("R4 READY after cancel", v, 32'd1);
    repeat (3) @(negedge clk);
    c1 = wrCount;
    repeat (30) @(negedge clk);
    chk("R4 writes stop after cancel", 32'(wrCount), 32'(c1));
    chk("R4 walk cut short", {31'd0, c1 < 256}, 32'd1);
    regRd(8'h08, v); chk("R4 no done bit on cancel", v, 32'd0);

    // R10 second engine waits for the first, then is served
    putArea(32'h100, 0, 0, 15, 3, 32'h001, 32'h400, 0, 60);
    putArea(32'h200, 16, 10, 23, 11, 32'h101, 32'h800, 0, 61);
    clearModel();
    regWr(8'h10, 32'h100);
    regWr(8'h14, 32'h200);
    waitReady(0);
    regRd(8'h24, v); chk("R10 engine 1 still waiting", v, 32'd0);
    waitReady(1);
    regRd(8'h24, v); chk("R10 engine 1 served afterwards", v, 32'd1);
    chk("R10 total writes", 32'(wrCount), 32'd80);
    checkArea("R10 engine 0 area", 0, 0, 15, 3, 0, 32'h400);
    checkArea("R10 engine 1 area", 16, 10, 23, 11, 1, 32'h800);
    regRd(8'h08, v); chk("R9 both lanes done", v, 32'h0000_0202);
    regWr(8'h08, 32'h0000_0002);
    regRd(8'h08, v); chk("R9 clearing one lane keeps the other", v, 32'h0000_0200);
    chk("R9 irq still high", {31'd0, irq}, 32'd1);
    clearIrq(32'h0000_0200);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule